// File: doc/BRIEF.md
# Single-Frame Transmit Buffer

This block sits between a host register port and a byte-wide MAC transmit interface. The host loads one outgoing frame as a run of 32-bit words pushed into one data register. It then arms the frame with one write to the control register, which carries the byte length and a go flag. The block sends the buffered bytes, most significant byte of each word first, over a valid/ready byte stream. It stops after exactly the programmed number of bytes.

Completion uses the same go flag that software set. The hardware clears go once the last byte has been taken, and in the same cycle it sets a sticky done cause. That cause drives the interrupt line when its enable bit is set. Only one frame is in flight at a time. Data pushes that arrive while a frame is armed, or that exceed the buffer, are dropped and set an error flag. A control write made while idle rewinds the buffer and clears the error flag.

Top module: `tx_frame_buf`

## Requirements
- R1: After reset the control register, the interrupt enable and the done cause all read 0, and mac_valid and irq are 0.
- R2: The control register at offset 0x800 holds the length in bits [10:0], the error flag in bit 14 and go in bit 15. The data register is at 0x808, the interrupt enable is bit 0 at 0x820, and the done cause is bit 0 at 0x824. Any other offset, and the data register itself, reads as 0.
- R3: A control write while go is 0 rewinds the word buffer to word 0 and loads the length and the go flag from the written value. Data writes made while go is 0 are stored in order from word 0.
- R4: While go is 1, the block emits exactly length bytes: words in load order, and within each word bits [31:24] first and bits [7:0] last. mac_valid is 0 whenever go is 0.
- R5: A byte offered with mac_ready low stays offered, unchanged, in the next cycle.
- R6: One cycle after the last byte is accepted, go reads 0 and the done cause is 1. A frame of length 0 completes the same way without offering any byte.
- R7: A data write while go is 1 is ignored and sets the error flag.
- R8: A data write beyond the 512-word capacity (at the default 11-bit length) is ignored and sets the error flag.
- R9: A control write while go is 0 clears the error flag. A control write while go is 1 has no effect.
- R10: irq is the done cause ANDed with the enable bit. Writing 1 to cause bit 0 clears it, writing 0 leaves it unchanged, and a completion in the same cycle as a clear wins.
- R11: Each new frame is read from word 0 of the buffer, regardless of earlier frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | ADDR_W | Register byte offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr |
| mac_valid | output | 1 | Byte offered to the MAC |
| mac_ready | input | 1 | MAC accepts the offered byte |
| mac_data | output | 8 | Offered byte |
| irq | output | 1 | Transmit-done interrupt |

## Verification
A wrong byte counter shows up on the MAC stream as a byte out of order, a missing byte or an extra byte. It also shows as go clearing too early or too late, which is visible one cycle after the last handshake. A wrong write pointer shows as bytes from the wrong words in the next frame that is sent, so each frame is loaded from fresh data with a different pattern. A wrong error flag or done cause reads back wrongly at the first register read after the event that should have changed it.

// File: rtl/tx_frame_buf_pkg.sv
`timescale 1ns/1ps
package tx_frame_buf_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [11:0] OFS_CTRL  = 12'h800;
  localparam logic [11:0] OFS_DATA  = 12'h808;
  localparam logic [11:0] OFS_IEN   = 12'h820;
  localparam logic [11:0] OFS_CAUSE = 12'h824;
  localparam int unsigned GO_BIT    = 15;
  localparam int unsigned ERR_BIT   = 14;
endpackage

// File: rtl/tx_word_store.sv
`timescale 1ns/1ps
module tx_word_store #(
  parameter int unsigned IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [31:0]      push_word,
  input  logic             rewind,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word,
  output logic             full
);
  localparam int unsigned DEPTH = 2 ** IDX_W;

  logic [31:0]    mem [DEPTH];
  logic [IDX_W:0] wptr_q, wptr_d;
  logic           wptr_en, mem_we;

  assign full   = wptr_q[IDX_W];
  assign mem_we = push && !full;

  always_comb begin
    wptr_en = rewind || mem_we;
    wptr_d  = rewind ? '0 : wptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wptr_q <= '0;
    else if (wptr_en) wptr_q <= wptr_d;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wptr_q[IDX_W-1:0]] <= push_word;
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/tx_byte_serializer.sv
`timescale 1ns/1ps
module tx_byte_serializer #(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  input  logic             restart,
  input  logic             mac_ready,
  input  logic [31:0]      rd_word,
  output logic [LEN_W-3:0] rd_idx,
  output logic             mac_valid,
  output logic [7:0]       mac_data,
  output logic             fin
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [1:0]       lane;

  assign mac_valid = go && (cnt_q != len);
  assign fin       = go && (cnt_q == len);
  assign rd_idx    = cnt_q[LEN_W-1:2];
  assign lane      = 2'd3 - cnt_q[1:0];
  assign mac_data  = rd_word[{lane, 3'b000} +: 8];

  always_comb begin
    cnt_en = restart || (mac_valid && mac_ready);
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tx_ctrl_regs.sv
`timescale 1ns/1ps
module tx_ctrl_regs
  import tx_frame_buf_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  input  logic              fin,
  input  logic              full,
  output logic              go,
  output logic [LEN_W-1:0]  len,
  output logic              err,
  output logic              irq_en,
  output logic              cause,
  output logic              irq,
  output logic              data_push,
  output logic              ctl_accept,
  output logic [31:0]       host_rdata
);
  logic sel_ctrl, sel_data, sel_ien, sel_cause;
  logic go_d, err_d, ien_d, cause_d;
  logic go_en, len_en, err_en, ien_en, cause_en;
  logic unused_wbits;

  assign sel_ctrl  = host_addr == ADDR_W'(OFS_CTRL);
  assign sel_data  = host_addr == ADDR_W'(OFS_DATA);
  assign sel_ien   = host_addr == ADDR_W'(OFS_IEN);
  assign sel_cause = host_addr == ADDR_W'(OFS_CAUSE);

  assign ctl_accept   = host_we && sel_ctrl && !go;
  assign data_push    = host_we && sel_data && !go;
  assign unused_wbits = ^{host_wdata[31:16], host_wdata[13:LEN_W]};

  always_comb begin
    go_en    = ctl_accept || fin;
    go_d     = ctl_accept ? host_wdata[GO_BIT] : 1'b0;
    len_en   = ctl_accept;
    err_en   = ctl_accept || (host_we && sel_data && (go || full));
    err_d    = !ctl_accept;
    ien_en   = host_we && sel_ien;
    ien_d    = host_wdata[0];
    cause_en = fin || (host_we && sel_cause && host_wdata[0]);
    cause_d  = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go    <= 1'b0;
      len   <= '0;
      err   <= 1'b0;
      irq_en <= 1'b0;
      cause <= 1'b0;
    end else begin
      if (go_en)    go     <= go_d;
      if (len_en)   len    <= host_wdata[LEN_W-1:0];
      if (err_en)   err    <= err_d;
      if (ien_en)   irq_en <= ien_d;
      if (cause_en) cause  <= cause_d;
    end
  end

  assign irq = cause && irq_en;

  always_comb begin
    host_rdata = '0;
    if (sel_ctrl) begin
      host_rdata[LEN_W-1:0] = len;
      host_rdata[ERR_BIT]   = err;
      host_rdata[GO_BIT]    = go;
    end else if (sel_ien) begin
      host_rdata[0] = irq_en;
    end else if (sel_cause) begin
      host_rdata[0] = cause;
    end
  end
endmodule

// File: rtl/tx_frame_buf.sv
`timescale 1ns/1ps
module tx_frame_buf #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              mac_valid,
  input  logic              mac_ready,
  output logic [7:0]        mac_data,
  output logic              irq
);
  localparam int unsigned IDX_W = LEN_W - 2;

  logic             go, err, irq_en, cause, fin, full;
  logic             data_push, ctl_accept;
  logic [LEN_W-1:0] len;
  logic [IDX_W-1:0] rd_idx;
  logic [31:0]      rd_word;

  tx_ctrl_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .fin(fin), .full(full), .go(go), .len(len),
    .err(err), .irq_en(irq_en), .cause(cause), .irq(irq),
    .data_push(data_push), .ctl_accept(ctl_accept), .host_rdata(host_rdata)
  );

  tx_word_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(data_push), .push_word(host_wdata),
    .rewind(ctl_accept), .rd_idx(rd_idx), .rd_word(rd_word), .full(full)
  );

  tx_byte_serializer #(.LEN_W(LEN_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .go(go), .len(len), .restart(ctl_accept),
    .mac_ready(mac_ready), .rd_word(rd_word), .rd_idx(rd_idx),
    .mac_valid(mac_valid), .mac_data(mac_data), .fin(fin)
  );
endmodule

// File: rtl/tx_frame_buf_chk.sv
`timescale 1ns/1ps
module tx_frame_buf_chk
  import tx_frame_buf_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [31:0]       host_wdata,
  input logic              mac_valid,
  input logic              mac_ready,
  input logic [7:0]        mac_data,
  input logic              go,
  input logic              fin,
  input logic              err,
  input logic              cause
);
  logic wr_data, wr_ctrl, wr_clr;
  logic unused_chk;
  assign wr_data    = host_we && host_addr == ADDR_W'(OFS_DATA);
  assign wr_ctrl    = host_we && host_addr == ADDR_W'(OFS_CTRL);
  assign wr_clr     = host_we && host_addr == ADDR_W'(OFS_CAUSE) && host_wdata[0];
  assign unused_chk = ^host_wdata[31:1];

  // R5
  a_r5_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid && !mac_ready |=> mac_valid && $stable(mac_data));
  // R6
  a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !go && cause);
  // R4
  a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !mac_valid);
  // R7
  a_r7_busy_push_err: assert property (@(posedge clk) disable iff (!rst_n)
    go && wr_data |=> err);
  // R9
  a_r9_busy_ctrl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    go && !fin && wr_ctrl |=> go);
  // R10
  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cause && !wr_clr |=> cause);
endmodule

bind tx_frame_buf tx_frame_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .mac_valid(mac_valid), .mac_ready(mac_ready),
  .mac_data(mac_data), .go(go), .fin(fin), .err(err), .cause(cause)
);

// File: tb/tx_frame_buf_bench.sv
`timescale 1ns/1ps
module tx_frame_buf_bench;
  localparam logic [11:0] A_CTRL = 12'h800, A_DATA = 12'h808;
  localparam logic [11:0] A_IEN = 12'h820, A_CAUSE = 12'h824;
  localparam logic [31:0] GO = 32'h8000;

  logic        clk, rst_n, host_we, mac_ready, mac_valid, irq;
  logic [11:0] host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic [7:0]  mac_data;

  int n_chk, n_err, rx_n;
  logic [7:0] rx_b  [2048];
  logic [7:0] exp_b [2048];
  bit   stall_pend;
  logic [7:0] stall_byte;

  tx_frame_buf u_tx_frame_buf (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mac_valid(mac_valid),
    .mac_ready(mac_ready), .mac_data(mac_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // collector: samples just after the falling edge, i.e. the values the next rising edge sees
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (stall_pend) begin
        n_chk++;
        if (!(mac_valid && mac_data == stall_byte)) begin
          n_err++;
          $display("FAIL R5 held byte actual=%0h expected=%0h", mac_data, stall_byte);
        end
      end
      stall_pend = mac_valid && !mac_ready;
      stall_byte = mac_data;
      if (mac_valid && mac_ready) begin
        rx_b[rx_n] = mac_data;
        rx_n++;
      end
    end
  end

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s + i * 13) & 255);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] r);
    host_addr = a;
    #1;
    r = host_rdata;
  endtask

  task automatic load(input int n, input int s);
    wr(A_CTRL, 32'h0);
    for (int w = 0; w < (n + 3) / 4; w++)
      wr(A_DATA, {pat(s, 4*w), pat(s, 4*w+1), pat(s, 4*w+2), pat(s, 4*w+3)});
    for (int i = 0; i < n; i++) exp_b[i] = pat(s, i);
    wr(A_CAUSE, 32'h1);
    rx_n = 0;
  endtask

  task automatic drain(input int n, input bit stall, input string tag);
    int lag, mism;
    bit done;
    logic [31:0] r;
    lag = 0; mism = 0; done = 0;
    for (int c = 0; c < 20000 && !done; c++) begin
      @(negedge clk);
      mac_ready = stall ? ((c % 3) != 2) : 1'b1;
      rd(A_CTRL, r);
      if (!r[15]) done = 1;
      else if (rx_n == n) lag++;
    end
    mac_ready = 1'b0;
    chk(done, {tag, " R6 go cleared"}, 32'(done), 1);
    chk(lag == 1, {tag, " R6 one-cycle clear"}, lag, 1);
    chk(rx_n == n, {tag, " R4 byte count"}, rx_n, n);
    for (int i = 0; i < n; i++) if (rx_b[i] !== exp_b[i]) mism++;
    chk(mism == 0, {tag, " R4 R11 byte order"}, mism, 0);
    rd(A_CAUSE, r);
    chk(r[0] == 1'b1, {tag, " R6 cause set"}, r, 1);
    rd(A_CTRL, r);
    chk(r[10:0] == 11'(n), {tag, " R2 length readback"}, r[10:0], n);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    rd(A_CTRL, r);  chk(r == 0, "R1 ctrl", r, 0);
    rd(A_IEN, r);   chk(r == 0, "R1 enable", r, 0);
    rd(A_CAUSE, r); chk(r == 0, "R1 cause", r, 0);
    chk(!mac_valid && !irq, "R1 outputs", {mac_valid, irq}, 0);
    rd(12'h004, r); chk(r == 0, "R2 unmapped", r, 0);
  endtask

  task automatic t_basic;
    logic [31:0] r;
    load(6, 1);
    wr(A_CTRL, GO | 32'd6);
    drain(6, 1'b0, "basic");
    chk(!irq, "R10 irq masked", irq, 0);
    rd(A_DATA, r); chk(r == 0, "R2 data reads zero", r, 0);
  endtask

  task automatic t_irq;
    logic [31:0] r;
    wr(A_IEN, 32'h1);
    chk(irq, "R10 irq on enable", irq, 1);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, r); chk(r[0], "R10 write0 keeps cause", r, 1);
    wr(A_CAUSE, 32'h1);
    rd(A_CAUSE, r); chk(r[0] == 0, "R10 w1c clears", r, 0);
    chk(!irq, "R10 irq drops", irq, 0);
    wr(A_IEN, 32'h0);
  endtask

  task automatic t_stall;
    load(5, 77);
    wr(A_CTRL, GO | 32'd5);
    drain(5, 1'b1, "stall R5 R11");
  endtask

  task automatic t_zero;
    logic [31:0] r;
    load(0, 3);
    wr(A_CTRL, GO);
    rd(A_CTRL, r); chk(r[15], "R6 zero-length armed", r, GO);
    @(negedge clk);
    rd(A_CTRL, r); chk(r[15] == 0, "R6 zero-length done", r, 0);
    rd(A_CAUSE, r); chk(r[0], "R6 zero-length cause", r, 1);
    chk(rx_n == 0, "R6 zero-length no bytes", rx_n, 0);
  endtask

  task automatic t_busy;
    logic [31:0] r;
    load(8, 40);
    wr(A_CTRL, GO | 32'd8);
    wr(A_DATA, 32'hDEADBEEF);
    rd(A_CTRL, r); chk(r[14], "R7 busy push sets err", r, 32'h4000);
    wr(A_CTRL, GO | 32'd3);
    rd(A_CTRL, r); chk(r[15] && r[10:0] == 11'd8, "R9 busy ctrl ignored", r, 32'hC008);
    drain(8, 1'b0, "busy R7");
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, r); chk(r[14] == 0, "R9 idle ctrl clears err", r, 0);
  endtask

  task automatic t_overflow;
    logic [31:0] r;
    wr(A_CTRL, 32'h0);
    for (int w = 0; w < 512; w++) wr(A_DATA, 32'(w));
    rd(A_CTRL, r); chk(r[14] == 0, "R8 capacity fill no err", r, 0);
    wr(A_DATA, 32'h1234);
    rd(A_CTRL, r); chk(r[14], "R8 overflow sets err", r, 32'h4000);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, r); chk(r[14] == 0, "R9 clear after overflow", r, 0);
    load(9, 200);
    wr(A_CTRL, GO | 32'd9);
    drain(9, 1'b0, "rewind R3 R11");
  endtask

  initial begin
    n_chk = 0; n_err = 0; rx_n = 0; stall_pend = 0; stall_byte = 0;
    rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0; mac_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_irq();
    t_stall();
    t_zero();
    t_busy();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule